// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a byte-wide memory with two independent access ports, called left and right. Each port has its own active-low select, a write strobe, an address and separate write and read data buses. Either port can read or write any word at any time. Both ports run on one shared clock. Read data is registered and appears on the cycle after the access.

The two highest addresses can also serve as mailboxes. This mode is turned on by a configuration input. The word one below the top is the left port's inbox. When the right port writes it, the left port's active-low interrupt goes low. The interrupt is released when the left port reads that word. The top word is the right port's inbox and works the same way in the other direction. The mailbox byte itself is ordinary user data kept in the array. When the mode is off, both words are plain storage and the interrupt outputs never move.

The default address width gives a 2K-word array so that elaboration stays small. Setting `ADDR_W` to 13 gives the full 8K-word arrangement, with the inboxes at 0x1FFE and 0x1FFF.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: While reset is held, and on the first cycle after it, `l_irq_n` and `r_irq_n` are 1 and both read data buses are 0.
- R2: A port with its select low and `wr`=0 reads the word at its address. The value appears on its read bus one clock later. The read bus keeps its value on cycles without a read. A port with `wr`=1 stores its write data at its address. The two ports act independently of each other.
- R3: With `mbox_en`=1, a right-port write to address 2^ADDR_W−2 drives `l_irq_n` to 0 on the next cycle.
- R4: With `mbox_en`=1, a left-port read of address 2^ADDR_W−2 returns `l_irq_n` to 1 on the next cycle.
- R5: With `mbox_en`=1, a left-port write to address 2^ADDR_W−1 drives `r_irq_n` to 0 on the next cycle. A right-port read of that address returns `r_irq_n` to 1.
- R6: A byte written to a mailbox address is stored and read back unchanged, like any other word.
- R7: With `mbox_en`=0, accesses to the two top addresses act as plain memory, and neither interrupt output changes.
- R8: A port whose select is high performs no access. It writes nothing, its read bus holds, and it causes no interrupt change.
- R9: If the set and the clear of one interrupt fall in the same cycle, the interrupt ends up asserted.
- R10: Some accesses leave both interrupts unchanged: a port writing its own inbox, and a port reading the other side's inbox.
- R11: When both ports write the same address in one cycle, the left port's data is stored.
- R12: When one port reads an address that the other port writes in the same cycle, the read returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_en | input | 1 | 1 enables the mailbox interrupt function |
| l_cs_n | input | 1 | Left port select, active low |
| l_wr | input | 1 | Left port write strobe (1 write, 0 read) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_cs_n | input | 1 | Right port select, active low |
| r_wr | input | 1 | Right port write strobe (1 write, 0 read) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Each interrupt flag is one register, so any set, clear or priority fault shows on the matching `*_irq_n` pin one clock after the access that caused it. A fault in the address decode makes an interrupt move on an access that should leave it alone, such as a port writing its own inbox or any access while the mode is off. A storage or port-priority fault only appears at the next read of the affected word. For that reason the random phase reads the two mailbox words and their neighbours often, so that corrupted or misrouted data surfaces within a few cycles.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Address of a port's inbox: side 0 = left (top-1), side 1 = right (top)
  function automatic int unsigned inbox_addr(input int unsigned aw, input int unsigned side);
    return ((32'd1 << aw) - 32'd2) + side;
  endfunction

  // Decode select and strobe into an access kind
  function automatic acc_e access_kind(input logic cs_n, input logic wr);
    if (cs_n) return ACC_IDLE;
    return wr ? ACC_WRITE : ACC_READ;
  endfunction

  // Next flag value; a set outranks a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned IN_ADDR  = 0,
  parameter int unsigned OUT_ADDR = 1
) (
  input  logic              mbox_en,
  input  logic              cs_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic              inbox_read,
  output logic              outbox_write
);

  localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(IN_ADDR);
  localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OUT_ADDR);

  acc_e kind;

  always_comb begin
    kind         = access_kind(cs_n, wr);
    rd_en        = (kind == ACC_READ);
    wr_en        = (kind == ACC_WRITE);
    inbox_read   = mbox_en && rd_en && (addr == IN_A);
    outbox_write = mbox_en && wr_en && (addr == OUT_A);
  end

endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag
  import dpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= flag_next(pending_q, set, clr);
  end

  assign irq_n = ~pending_q;

endmodule

// File: rtl/dpm_mem_array.sv
module dpm_mem_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_rd,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Port b first, port a last: port a (left) wins an address collision
  always_ff @(posedge clk) begin
    if (b_we) store[b_addr] <= b_wdata;
    if (a_we) store[a_addr] <= a_wdata;
  end

  // Registered reads; nonblocking update returns pre-write contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= store[a_addr];
      if (b_rd) b_rdata <= store[b_addr];
    end
  end

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              l_cs_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam int unsigned L_INBOX = inbox_addr(ADDR_W, 0);
  localparam int unsigned R_INBOX = inbox_addr(ADDR_W, 1);

  logic l_rd_en, l_wr_en, r_rd_en, r_wr_en;
  logic set_l_evt, clr_l_evt, set_r_evt, clr_r_evt;
  logic [1:0] set_vec, clr_vec, irq_vec;

  dpm_port_decode #(.ADDR_W(ADDR_W), .IN_ADDR(L_INBOX), .OUT_ADDR(R_INBOX)) u_dec_l (
    .mbox_en      (mbox_en),
    .cs_n         (l_cs_n),
    .wr           (l_wr),
    .addr         (l_addr),
    .rd_en        (l_rd_en),
    .wr_en        (l_wr_en),
    .inbox_read   (clr_l_evt),
    .outbox_write (set_r_evt)
  );

  dpm_port_decode #(.ADDR_W(ADDR_W), .IN_ADDR(R_INBOX), .OUT_ADDR(L_INBOX)) u_dec_r (
    .mbox_en      (mbox_en),
    .cs_n         (r_cs_n),
    .wr           (r_wr),
    .addr         (r_addr),
    .rd_en        (r_rd_en),
    .wr_en        (r_wr_en),
    .inbox_read   (clr_r_evt),
    .outbox_write (set_l_evt)
  );

  dpm_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_rd    (l_rd_en),
    .a_we    (l_wr_en),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .b_rd    (r_rd_en),
    .b_we    (r_wr_en),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata)
  );

  assign set_vec = {set_r_evt, set_l_evt};
  assign clr_vec = {clr_r_evt, clr_l_evt};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    dpm_mbox_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec[g]),
      .clr   (clr_vec[g]),
      .irq_n (irq_vec[g])
    );
  end

  assign l_irq_n = irq_vec[0];
  assign r_irq_n = irq_vec[1];

endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              l_cs_n,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_irq_n,
  input logic              r_cs_n,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_irq_n,
  input logic              set_l_evt,
  input logic              clr_l_evt,
  input logic              set_r_evt,
  input logic              clr_r_evt
);

  localparam logic [ADDR_W-1:0] LBOX = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] RBOX = {ADDR_W{1'b1}};

  a_r3_right_write_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !r_cs_n && r_wr && r_addr == LBOX) |=> !l_irq_n);

  a_r4_left_read_clears_left: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !l_cs_n && !l_wr && l_addr == LBOX && !set_l_evt) |=> l_irq_n);

  a_r5_left_write_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !l_cs_n && l_wr && l_addr == RBOX) |=> !r_irq_n);

  a_r5_right_read_clears_right: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !r_cs_n && !r_wr && r_addr == RBOX && !set_r_evt) |=> r_irq_n);

  a_r7_disabled_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  a_r8_idle_ports_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n && r_cs_n) |=> ($stable(l_rdata) && $stable(r_rdata) && $stable(l_irq_n) && $stable(r_irq_n)));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_l_evt && clr_l_evt) |=> !l_irq_n);

  a_r10_left_falls_only_on_right_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(mbox_en && !r_cs_n && r_wr && r_addr == LBOX));

  a_r10_right_falls_only_on_left_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_irq_n) |-> $past(mbox_en && !l_cs_n && l_wr && l_addr == RBOX));

  a_r10_events_exclusive_ports: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_l_evt, clr_r_evt}) <= 1 && $countones({set_r_evt, clr_l_evt}) <= 1);

endmodule

bind dpm_mailbox_ram dpm_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dpm_mailbox_ram.sv
module sim_dpm_mailbox_ram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LBOX = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RBOX = AW'(DEPTH - 1);

  logic clk = 0;
  logic rst_n = 0;
  logic mbox_en = 0;
  logic l_cs_n = 1, l_wr = 0, r_cs_n = 1, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_lr = '0, exp_rr = '0;
  logic exp_lpend = 0, exp_rpend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected next state from the requirements
  function automatic logic [DW-1:0] next_rd(input logic cs_n, input logic wr,
                                            input logic [AW-1:0] a, input logic [DW-1:0] cur);
    return (!cs_n && !wr) ? ref_mem[a] : cur;
  endfunction

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic model_edge();
    logic sl, cl, sr, cr;
    sl = mbox_en && !r_cs_n && r_wr && r_addr == LBOX;
    cl = mbox_en && !l_cs_n && !l_wr && l_addr == LBOX;
    sr = mbox_en && !l_cs_n && l_wr && l_addr == RBOX;
    cr = mbox_en && !r_cs_n && !r_wr && r_addr == RBOX;
    exp_lr = next_rd(l_cs_n, l_wr, l_addr, exp_lr);
    exp_rr = next_rd(r_cs_n, r_wr, r_addr, exp_rr);
    exp_lpend = next_flag(exp_lpend, sl, cl);
    exp_rpend = next_flag(exp_rpend, sr, cr);
    if (!r_cs_n && r_wr) ref_mem[r_addr] = r_wdata;
    if (!l_cs_n && l_wr) ref_mem[l_addr] = l_wdata;
  endtask

  // One clock with the current drives, then compare at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "l_rdata", int'(l_rdata), int'(exp_lr));
    check(tag, "r_rdata", int'(r_rdata), int'(exp_rr));
    check(tag, "l_irq_n", int'(l_irq_n), int'(!exp_lpend));
    check(tag, "r_irq_n", int'(r_irq_n), int'(!exp_rpend));
  endtask

  task automatic drive(input logic lc, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic rc, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    l_cs_n = lc; l_wr = lw; l_addr = la; l_wdata = ld;
    r_cs_n = rc; r_wr = rw; r_addr = ra; r_wdata = rd;
  endtask

  task automatic idle();
    drive(1, 0, '0, '0, 1, 0, '0, '0);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int unsigned k = $urandom % 4;
    if (k < 2) return AW'(DEPTH - 4 + ($urandom % 4));
    return AW'($urandom % DEPTH);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "l_irq_n", int'(l_irq_n), 1);
    check("R1", "r_irq_n", int'(r_irq_n), 1);
    check("R1", "l_rdata", int'(l_rdata), 0);
    check("R1", "r_rdata", int'(r_rdata), 0);
    rst_n = 1;
    idle();
    step("R1");

    // Fill the array with known content, mailbox mode off (R2, R7)
    for (int i = 0; i < DEPTH / 2; i++) begin
      drive(0, 1, AW'(i), DW'(i * 7 + 3), 0, 1, AW'(i + DEPTH / 2), DW'(i * 13 + 1));
      step("R7");
    end
    // R7: disabled mode, plain storage at the top words
    drive(0, 1, RBOX, 8'h11, 0, 1, LBOX, 8'h22);
    step("R7");
    drive(0, 0, LBOX, 0, 0, 0, RBOX, 0);
    step("R7");

    mbox_en = 1;
    // R2: independent reads on both ports
    drive(0, 0, AW'(5), 0, 0, 0, AW'(DEPTH - 9), 0);
    step("R2");
    // R3 + R6: right writes left inbox
    drive(1, 0, '0, '0, 0, 1, LBOX, 8'hA5);
    step("R3");
    // R10: left writes its own inbox, right reads left inbox
    drive(0, 1, LBOX, 8'h5A, 1, 0, '0, '0);
    step("R10");
    drive(1, 0, '0, '0, 0, 0, LBOX, '0);
    step("R10");
    // R6 + R4: left reads inbox, clears
    drive(0, 0, LBOX, '0, 1, 0, '0, '0);
    step("R4");
    // R5: left writes right inbox, right reads it
    drive(0, 1, RBOX, 8'h3C, 1, 0, '0, '0);
    step("R5");
    drive(1, 0, '0, '0, 0, 0, RBOX, '0);
    step("R5");
    // R9 + R12: set and clear of left flag in one cycle
    drive(0, 0, LBOX, '0, 0, 1, LBOX, 8'hC3);
    step("R9");
    drive(0, 0, LBOX, '0, 1, 0, '0, '0);
    step("R6");
    // R8: deselected ports with strobes and mailbox addresses
    drive(1, 1, RBOX, 8'hEE, 1, 1, LBOX, 8'hEE);
    step("R8");
    drive(0, 0, RBOX, '0, 0, 0, LBOX, '0);
    step("R8");
    // R11: same-address write collision
    drive(0, 1, AW'(77), 8'h99, 0, 1, AW'(77), 8'h66);
    step("R11");
    drive(0, 0, AW'(77), '0, 1, 0, '0, '0);
    step("R11");
    // R7: disabled mailbox while flags pending
    drive(0, 1, RBOX, 8'h01, 1, 0, '0, '0);
    step("R5");
    mbox_en = 0;
    drive(1, 0, '0, '0, 0, 0, RBOX, '0);
    step("R7");
    drive(1, 0, '0, '0, 0, 1, LBOX, 8'h02);
    step("R7");
    mbox_en = 1;

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      drive($urandom % 4 == 0, $urandom % 2, pick_addr(), DW'($urandom),
            $urandom % 4 == 0, $urandom % 2, pick_addr(), DW'($urandom));
      if ($urandom % 16 == 0) mbox_en = ~mbox_en;
      step("R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule